// File: doc/BRIEF.md
# Source-to-buffer word fetch engine

This block pulls a run of words from a source memory into a small internal buffer. A start pulse loads a base address, a word count and the choice between two bus master ports. The engine then raises a request with the current read address on the chosen port. It holds that request until the port acknowledges, and it writes the returned word into the buffer in the acknowledge cycle. The address then moves forward by one word and the remaining count drops by one.

The engine throttles itself. When the buffer has no free entry, or when the pause input is high, it starts no new read and leaves the bus idle. A request that is already on the bus is never withdrawn; it stays up until it is acknowledged. When the last word has been written, the engine drops busy and gives a single-cycle done pulse.

The buffer drains through a valid/ready stream. `out_valid` is high while the buffer holds a word, and `out_data` shows the oldest word. A word leaves on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` does not change. Holding `out_ready` low fills the buffer, and that back-pressure stops the read requests.

Top module: `fill_engine`

## Requirements
- R1: After reset, busy, done, out_valid and both port requests are 0.
- R2: A start pulse seen while idle loads the descriptor. On the next clock edge the selected port's request rises with the base address, provided pause is low and the buffer has room. A start pulse seen while busy is ignored.
- R3: Once a request is up, it stays up and its address does not change until the port acknowledges (ack high at a clock edge while the request is high), whether or not pause rises meanwhile.
- R4: Each acknowledged word enters the buffer and is presented on `out_data` in arrival order, with `out_valid` high from the following cycle. While `out_valid` is high and `out_ready` is low, `out_data` stays stable.
- R5: The read address advances by DW/8 (4 for the default DW of 32) after each acknowledged word.
- R6: While the buffer holds DEPTH words, no request is raised. On the clock edge that drains an entry, a request rises again if words remain and pause is low.
- R7: While pause is high and no request is up, no new request rises. The first clock edge that samples pause low raises the request again.
- R8: `start_port` 0 selects port m0 and 1 selects port m1. The other port's request and address stay 0, and its ack and read data have no effect.
- R9: Exactly as many words are requested as the loaded count. The count drops only on an acknowledged word.
- R10: `done` is high for exactly one cycle, in the cycle after the last acknowledge, and busy is low in that same cycle.
- R11: A start with a count of 0 issues no request and gives the done pulse on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load the descriptor and begin (while idle) |
| start_addr | input | AW | Byte address of the first word |
| start_len | input | CW | Number of words to fetch |
| start_port | input | 1 | Master port select, 0 = m0, 1 = m1 |
| pause | input | 1 | Hold off new reads while high |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Single-cycle pulse when the run is complete |
| m0_req | output | 1 | Read request on port m0 |
| m0_addr | output | AW | Read address on port m0 |
| m0_ack | input | 1 | Acknowledge from port m0 |
| m0_rdata | input | DW | Read data from port m0 |
| m1_req | output | 1 | Read request on port m1 |
| m1_addr | output | AW | Read address on port m1 |
| m1_ack | input | 1 | Acknowledge from port m1 |
| m1_rdata | input | DW | Read data from port m1 |
| out_valid | output | 1 | The buffer holds a word |
| out_ready | input | 1 | The consumer takes the word |
| out_data | output | DW | Oldest buffered word |

## Verification
A wrong address or count register shows up at the next request, one cycle after the faulty acknowledge: the address is off by a word, or the run ends too early or too late. A bad buffer level shows as a request raised while the buffer is full, or as a stall with free entries, in the cycle after the level goes wrong. Bad buffer pointers show as reordered or repeated words on `out_data` one cycle after the write. Pause and select faults show as a request on the wrong port or while paused on the next edge, and a mishandled final count moves or stretches the done pulse.

// File: rtl/fill_pkg.sv
package fill_pkg;
  localparam int unsigned NUM_PORTS = 2;

  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_sel_e;
endpackage

// File: rtl/fill_fifo.sv
module fill_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o,
  output logic [LW-1:0] level_o,
  output logic          pop_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          push_ok;

  assign out_valid_o = (level_q != '0);
  assign pop_o       = out_valid_o && out_ready_i;
  assign push_ok     = push_i && ((level_q != LW'(DEPTH)) || pop_o);
  assign out_data_o  = slot_q[rd_ptr_q];
  assign level_o     = level_q;

  always_ff @(posedge clk) begin
    if (push_ok) slot_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_o)   rd_ptr_q <= (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      level_q <= level_q + LW'(push_ok) - LW'(pop_o);
    end
  end
endmodule

// File: rtl/fill_seq.sv
module fill_seq
  import fill_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CW    = 16,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LW    = $clog2(DEPTH + 1),
  parameter int unsigned WB    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] len_i,
  input  port_sel_e     port_i,
  input  logic          pause_i,
  input  logic          ack_i,
  input  logic [LW-1:0] level_i,
  input  logic          pop_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output port_sel_e     port_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          push_o
);
  logic          req_q, busy_q, done_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  port_sel_e     port_q;
  logic          xfer, launch, room;
  logic [LW:0]   proj_level;

  assign xfer       = req_q && ack_i;
  assign launch     = start_i && !busy_q;
  assign proj_level = {1'b0, level_i} + (LW + 1)'(xfer) - (LW + 1)'(pop_i);
  assign room       = proj_level < (LW + 1)'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      port_q <= PORT_A;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        addr_q <= base_i;
        rem_q  <= len_i;
        port_q <= port_i;
        busy_q <= (len_i != '0);
        done_q <= (len_i == '0);
        req_q  <= (len_i != '0) && !pause_i && room;
      end else if (busy_q) begin
        if (xfer) begin
          addr_q <= addr_q + AW'(WB);
          rem_q  <= rem_q - 1'b1;
        end
        if (xfer && (rem_q == CW'(1))) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          req_q  <= 1'b0;
        end else if (req_q && !ack_i) begin
          req_q <= 1'b1;
        end else begin
          req_q <= !pause_i && room;
        end
      end
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
  assign port_o = port_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign push_o = xfer;
endmodule

// File: rtl/fill_port_mux.sv
module fill_port_mux #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned NP = 2,
  parameter int unsigned SW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic [SW-1:0]    sel_i,
  input  logic             req_i,
  input  logic [AW-1:0]    addr_i,
  output logic [NP-1:0]    req_o,
  output logic [NP*AW-1:0] addr_o,
  input  logic [NP-1:0]    ack_i,
  input  logic [NP*DW-1:0] rdata_i,
  output logic             ack_o,
  output logic [DW-1:0]    rdata_o
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic hit;
    assign hit                = (sel_i == SW'(p));
    assign req_o[p]           = req_i && hit;
    assign addr_o[p*AW +: AW] = hit ? addr_i : '0;
  end

  assign ack_o   = ack_i[sel_i];
  assign rdata_o = rdata_i[sel_i*DW +: DW];
endmodule

// File: rtl/fill_engine.sv
module fill_engine
  import fill_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned CW    = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] start_len,
  input  logic          start_port,
  input  logic          pause,
  output logic          busy,
  output logic          done,
  output logic          m0_req,
  output logic [AW-1:0] m0_addr,
  input  logic          m0_ack,
  input  logic [DW-1:0] m0_rdata,
  output logic          m1_req,
  output logic [AW-1:0] m1_addr,
  input  logic          m1_ack,
  input  logic [DW-1:0] m1_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int unsigned WB = DW / 8;
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam int unsigned NP = NUM_PORTS;

  logic          seq_req, push, pop, sel_ack;
  logic [AW-1:0] seq_addr;
  logic [DW-1:0] sel_rdata;
  logic [LW-1:0] buf_level;
  port_sel_e     port_q;
  logic [0:0]    sel_w;
  logic [NP-1:0]    req_v, ack_v;
  logic [NP*AW-1:0] addr_v;
  logic [NP*DW-1:0] rdata_v;

  assign sel_w   = port_q;
  assign ack_v   = {m1_ack, m0_ack};
  assign rdata_v = {m1_rdata, m0_rdata};
  assign m0_req  = req_v[0];
  assign m1_req  = req_v[1];
  assign m0_addr = addr_v[0 +: AW];
  assign m1_addr = addr_v[AW +: AW];

  fill_seq #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .LW(LW), .WB(WB)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .base_i(start_addr), .len_i(start_len),
    .port_i(port_sel_e'(start_port)), .pause_i(pause),
    .ack_i(sel_ack), .level_i(buf_level), .pop_i(pop),
    .req_o(seq_req), .addr_o(seq_addr), .port_o(port_q),
    .busy_o(busy), .done_o(done), .push_o(push)
  );

  fill_port_mux #(.AW(AW), .DW(DW), .NP(NP), .SW(1)) u_mux (
    .sel_i(sel_w), .req_i(seq_req), .addr_i(seq_addr),
    .req_o(req_v), .addr_o(addr_v),
    .ack_i(ack_v), .rdata_i(rdata_v),
    .ack_o(sel_ack), .rdata_o(sel_rdata)
  );

  fill_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .push_i(push), .wdata_i(sel_rdata),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .level_o(buf_level), .pop_o(pop)
  );
endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m0_req,
  input logic          m0_ack,
  input logic [AW-1:0] m0_addr,
  input logic          m1_req,
  input logic          m1_ack,
  input logic [AW-1:0] m1_addr,
  input logic          pause,
  input logic          busy,
  input logic          done,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [LW-1:0] level
);
  localparam int unsigned WB = DW / 8;

  // R3
  m0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m0_req && !m0_ack |=> m0_req && $stable(m0_addr));
  // R3
  m1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m1_req && !m1_ack |=> m1_req && $stable(m1_addr));
  // R5
  m0_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m0_req && m0_ack |=> m0_addr == $past(m0_addr) + AW'(WB));
  // R6
  full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LW'(DEPTH)) |-> !m0_req && !m1_req);
  // R7
  pause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause && !m0_req && !m1_req |=> !m0_req && !m1_req);
  // R8
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({m0_req, m1_req}) <= 1);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m0_req && !m1_req);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);
  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind fill_engine fill_engine_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .m0_req(m0_req), .m0_ack(m0_ack), .m0_addr(m0_addr),
  .m1_req(m1_req), .m1_ack(m1_ack), .m1_addr(m1_addr),
  .pause(pause), .busy(busy), .done(done),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .level(buf_level)
);

// File: tb/test_fill_engine.sv
module test_fill_engine;
  localparam int AW = 32, DW = 32, CW = 16, DEPTH = 4, NV = 4;

  logic clk = 0, rst_n = 0;
  logic start = 0, start_port = 0, pause = 0, out_ready = 1;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] start_len = '0;
  logic m0_ack = 0, m1_ack = 0;
  logic [DW-1:0] m0_rdata = '0, m1_rdata = '0;
  logic busy, done, m0_req, m1_req, out_valid;
  logic [AW-1:0] m0_addr, m1_addr;
  logic [DW-1:0] out_data;
  int checks = 0, errors = 0;

  // Vector table: base address, word count, port, wait cycles before ack
  localparam logic [31:0] V_ADDR [NV] = '{32'h0000_1000, 32'h0000_2040, 32'h8000_0000, 32'h0000_0FF8};
  localparam int          V_LEN  [NV] = '{3, 5, 2, 4};
  localparam logic        V_PORT [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam int          V_WAIT [NV] = '{0, 2, 1, 0};

  always #2 clk = ~clk;

  fill_engine #(.AW(AW), .DW(DW), .CW(CW), .DEPTH(DEPTH)) i_fill_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .start_port(start_port), .pause(pause),
    .busy(busy), .done(done),
    .m0_req(m0_req), .m0_addr(m0_addr), .m0_ack(m0_ack), .m0_rdata(m0_rdata),
    .m1_req(m1_req), .m1_addr(m1_addr), .m1_ack(m1_ack), .m1_rdata(m1_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic req_of(input logic p);
    return p ? m1_req : m0_req;
  endfunction

  function automatic logic [AW-1:0] addr_of(input logic p);
    return p ? m1_addr : m0_addr;
  endfunction

  task automatic begin_run(input logic [AW-1:0] a, input int n, input logic p);
    start_addr = a; start_len = CW'(n); start_port = p; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // Wait for a request on port p, check the address, hold for w cycles, then acknowledge.
  task automatic serve(input logic p, input logic [AW-1:0] exp_a, input int w, input string rq);
    int n = 0;
    while (!req_of(p) && n < 40) begin @(negedge clk); n++; end
    chk(req_of(p) == 1'b1, rq, 64'(req_of(p)), 64'd1);
    chk(addr_of(p) == exp_a, "R5 address", 64'(addr_of(p)), 64'(exp_a));
    chk((p ? m0_req : m1_req) == 1'b0, "R8 other port idle", 64'(p ? m0_req : m1_req), 64'd0);
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      chk(req_of(p) && addr_of(p) == exp_a, "R3 request held", 64'(addr_of(p)), 64'(exp_a));
    end
    if (p) begin m1_ack = 1; m1_rdata = word_of(exp_a); end
    else   begin m0_ack = 1; m0_rdata = word_of(exp_a); end
    @(negedge clk);
    if (p) m1_ack = 0; else m0_ack = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !m0_req && !m1_req && !out_valid, "R1 reset outputs",
        64'({busy, done, m0_req, m1_req, out_valid}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !m0_req && !m1_req, "R1 idle after reset", 64'({busy, m0_req, m1_req}), 64'd0);

    // Table-driven runs; the other port acks constantly with junk (R8)
    for (int v = 0; v < NV; v++) begin
      if (V_PORT[v]) begin m0_ack = 1; m0_rdata = 32'hDEAD_BEEF; end
      else           begin m1_ack = 1; m1_rdata = 32'hDEAD_BEEF; end
      begin_run(V_ADDR[v], V_LEN[v], V_PORT[v]);
      chk(busy && req_of(V_PORT[v]) && addr_of(V_PORT[v]) == V_ADDR[v], "R2 first request",
          64'(addr_of(V_PORT[v])), 64'(V_ADDR[v]));
      for (int k = 0; k < V_LEN[v]; k++) begin
        logic [AW-1:0] ea;
        ea = V_ADDR[v] + AW'(4 * k);
        serve(V_PORT[v], ea, V_WAIT[v], "R9 request per word");
        chk(out_valid && out_data == word_of(ea), "R4 buffered word", 64'(out_data), 64'(word_of(ea)));
        if (k == V_LEN[v] - 1)
          chk(done && !busy, "R10 done with last word", 64'({done, busy}), 64'b10);
        else
          chk(!done && busy, "R9 run continues", 64'({done, busy}), 64'b01);
      end
      @(negedge clk);
      chk(!done && !req_of(V_PORT[v]), "R10 done single cycle, R9 no extra request",
          64'({done, req_of(V_PORT[v])}), 64'd0);
      m0_ack = 0; m1_ack = 0;
      @(negedge clk);
    end

    // R11 zero-length run
    begin_run(32'h0000_0300, 0, 1'b0);
    chk(done && !busy && !m0_req && !m1_req, "R11 zero length done", 64'({done, busy, m0_req, m1_req}), 64'b1000);
    @(negedge clk);
    chk(!done, "R11 done single cycle", 64'(done), 64'd0);

    // R2 start ignored while busy
    begin_run(32'h0000_4000, 2, 1'b0);
    start_addr = 32'h0000_9000; start_len = 5; start_port = 1; start = 1;
    @(negedge clk);
    start = 0;
    serve(1'b0, 32'h0000_4000, 0, "R2 first word kept");
    serve(1'b0, 32'h0000_4004, 0, "R2 second word kept");
    chk(done && !m1_req, "R2 second start ignored", 64'({done, m1_req}), 64'b10);
    @(negedge clk);

    // R6 buffer full stalls requests
    out_ready = 0;
    begin_run(32'h0000_5000, 6, 1'b0);
    for (int k = 0; k < DEPTH; k++) serve(1'b0, 32'h0000_5000 + AW'(4 * k), 0, "R6 fill");
    for (int k = 0; k < 4; k++) begin
      chk(!m0_req && busy, "R6 idle while full", 64'(m0_req), 64'd0);
      chk(out_valid && out_data == word_of(32'h0000_5000), "R4 held while stalled",
          64'(out_data), 64'(word_of(32'h0000_5000)));
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(m0_req && m0_addr == 32'h0000_5010, "R6 request after one drain", 64'(m0_addr), 64'h5010);
    chk(out_data == word_of(32'h0000_5004), "R4 order after drain", 64'(out_data), 64'(word_of(32'h0000_5004)));
    out_ready = 1;
    serve(1'b0, 32'h0000_5010, 0, "R6 word five");
    serve(1'b0, 32'h0000_5014, 1, "R6 word six");
    chk(done, "R10 done after stalled run", 64'(done), 64'd1);
    repeat (8) @(negedge clk);
    chk(!out_valid, "R4 buffer drained", 64'(out_valid), 64'd0);

    // R7 pause before start and during a held request
    pause = 1;
    begin_run(32'h0000_7000, 2, 1'b1);
    for (int k = 0; k < 4; k++) begin
      chk(!m1_req && busy, "R7 no request while paused", 64'(m1_req), 64'd0);
      @(negedge clk);
    end
    pause = 0;
    @(negedge clk);
    chk(m1_req && m1_addr == 32'h0000_7000, "R7 resume on next edge, R9 count kept",
        64'(m1_addr), 64'h7000);
    serve(1'b1, 32'h0000_7000, 0, "R7 first word");
    pause = 1;
    serve(1'b1, 32'h0000_7004, 2, "R3 held through pause");
    chk(done && !m1_req, "R9 exactly two words", 64'({done, m1_req}), 64'b10);
    pause = 0;
    repeat (3) @(negedge clk);
    chk(!m1_req && !busy, "R9 no extra request", 64'({m1_req, busy}), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule